// File: doc/BRIEF.md
# Nibble-Serial Firmware Bus Write Target

This block sits on the device side of a 4-bit, clocked firmware-hub style bus and decodes write cycles addressed to it. On every rising clock edge it samples the shared nibble bus and an active-low frame strobe. A write cycle opens with a start code while the strobe is low. An identity nibble follows and is compared against a strapped device ID. Then come seven address nibbles, one size nibble and two data nibbles. After that the host hands the bus over, the device returns a sync code, and the bus goes back to the host.

When a cycle completes, the block raises a one-cycle write strobe toward the memory core, with the assembled 28-bit address and the data byte held steady on its outputs. Cycles aimed at another ID, or cycles that ask for an unsupported transfer size, are dropped without any bus activity from the device. It then waits quietly for the next start code.

Top module: `nbus_write_target`

## Requirements
- R1: While reset is asserted and after its release, `bus_oe` and `wr_stb` are 0 until a valid cycle reaches the turnaround.
- R2: A cycle opens on a clock edge where `frame_n` is 0 and `bus_in` is 4'b1110. When several such edges occur in a row, the one just before `frame_n` goes high is the real start. A low `frame_n` edge with any other nibble returns the block to idle.
- R3: On the clock after the start, `bus_in` is compared with `dev_id`. On a mismatch the block stays silent for the whole cycle.
- R4: The next seven clocks carry the address, most-significant nibble first, and form the 28-bit `wr_addr`.
- R5: The clock after the address carries the size nibble. Only 4'b0000 is accepted; any other value makes the block drop the cycle silently.
- R6: The next two clocks carry the data byte, low nibble first, then high nibble, and form `wr_data`.
- R7: Clock 13 of the cycle is host-driven, and `bus_oe` stays 0 during it. During clock 14 the device drives 4'b1111 with `bus_oe` set.
- R8: During clock 15 the device drives 4'b0000 and raises `wr_stb` for exactly one cycle. At the same time `wr_addr` and `wr_data` hold the captured values.
- R9: During clock 16 the device drives 4'b1111, and during clock 17 `bus_oe` is 0. A new start on clock 18 is accepted.
- R10: A low `frame_n` edge in the middle of a cycle abandons that cycle. If the nibble on that edge is the start code, a new cycle begins from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, all fields sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble bus as seen at the pins |
| dev_id | input | 4 | Strapped device identity |
| bus_out | output | 4 | Nibble the device drives onto the bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| wr_addr | output | 28 | Captured write address |
| wr_data | output | 8 | Captured write data byte |
| wr_stb | output | 1 | One-cycle write request to the memory core |

## Verification
The identity nibble is swept through all sixteen values against a fixed strap, and the strap is swept with a matching identity. Together these separate an exact compare from a partial or inverted one. All sixteen size codes are sent, so only 4'b0000 yields a strobe. Walking-one addresses and all 256 data bytes expose swapped or shifted nibbles in either field. The remaining sequences cover runs of repeated starts, a restart in mid-address, an abort on a non-start low-strobe edge and back-to-back cycles; these tell apart restart, abort and idle behaviour.

// File: rtl/nbus_write_target.sv
module nbus_write_target #(
  parameter int         ADDR_NIBBLES = 7,
  parameter logic [3:0] START_CODE   = 4'b1110,
  parameter logic [3:0] SIZE_BYTE    = 4'b0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_n,
  input  logic [3:0]                bus_in,
  input  logic [3:0]                dev_id,
  output logic [3:0]                bus_out,
  output logic                      bus_oe,
  output logic [4*ADDR_NIBBLES-1:0] wr_addr,
  output logic [7:0]                wr_data,
  output logic                      wr_stb
);
  localparam int AW = 4 * ADDR_NIBBLES;
  localparam int CW = $clog2(ADDR_NIBBLES + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(ADDR_NIBBLES - 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ADDR, ST_SIZE, ST_DLO, ST_DHI,
    ST_TAR0, ST_TAR1, ST_SYNC, ST_TAR2, ST_TAR3
  } state_t;

  state_t        state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (!frame_n) begin
      state <= (bus_in == START_CODE) ? ST_ID : ST_IDLE;
    end else begin
      case (state)
        ST_ID: begin
          cnt   <= '0;
          state <= (bus_in == dev_id) ? ST_ADDR : ST_IDLE;
        end
        ST_ADDR: begin
          wr_addr <= {wr_addr[AW-5:0], bus_in};
          cnt     <= cnt + 1'b1;
          if (cnt == CNT_LAST) state <= ST_SIZE;
        end
        ST_SIZE: state <= (bus_in == SIZE_BYTE) ? ST_DLO : ST_IDLE;
        ST_DLO: begin
          wr_data[3:0] <= bus_in;
          state        <= ST_DHI;
        end
        ST_DHI: begin
          wr_data[7:4] <= bus_in;
          state        <= ST_TAR0;
        end
        ST_TAR0: state <= ST_TAR1;
        ST_TAR1: state <= ST_SYNC;
        ST_SYNC: state <= ST_TAR2;
        ST_TAR2: state <= ST_TAR3;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign bus_oe  = (state == ST_TAR1) || (state == ST_SYNC) || (state == ST_TAR2);
  assign bus_out = (state == ST_SYNC) ? 4'b0000 : 4'b1111;
  assign wr_stb  = (state == ST_SYNC);
endmodule

// File: rtl/nbus_write_target_chk.sv
module nbus_write_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_n,
  input logic [3:0] bus_out,
  input logic       bus_oe,
  input logic       wr_stb,
  input logic [7:0] wr_data
);
  AST_QUIET_IN_RESET: assert property (@(posedge clk) !rst_n |-> (!bus_oe && !wr_stb)); // R1
  AST_SYNC_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> (bus_oe && bus_out == 4'b0000)); // R8
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R8
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> $stable(wr_data)); // R6
  AST_DRIVE_LEADS_SYNC: assert property (@(posedge clk) disable iff (!rst_n) ($rose(bus_oe) && frame_n) |=> wr_stb); // R7
  AST_TAR_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n) (wr_stb && frame_n) |=> (bus_oe && bus_out == 4'b1111)); // R9
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (bus_oe && !wr_stb && $past(wr_stb)) |=> !bus_oe); // R9
endmodule

bind nbus_write_target nbus_write_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_out(bus_out),
  .bus_oe(bus_oe), .wr_stb(wr_stb), .wr_data(wr_data)
);

// File: tb/nbus_write_target_tb_top.sv
module nbus_write_target_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic [3:0]  bus_in = 4'hF;
  logic [3:0]  dev_id = 4'h5;
  logic [3:0]  bus_out;
  logic        bus_oe;
  logic [27:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_stb;
  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  nbus_write_target dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in), .dev_id(dev_id),
    .bus_out(bus_out), .bus_oe(bus_oe), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb)
  );

  task automatic step(input logic f, input logic [3:0] n);
    frame_n = f;
    bus_in  = n;
    @(negedge clk);
  endtask

  task automatic chk_val(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_io(input string req, input logic eoe, input logic [3:0] eout, input logic estb);
    logic [5:0] act;
    act = {bus_oe, bus_oe ? bus_out : 4'h0, wr_stb};
    chk_val(req, 32'(act), 32'({eoe, eoe ? eout : 4'h0, estb}));
  endtask

  task automatic run_frame(input logic [3:0] id, input logic [27:0] addr, input logic [3:0] size,
                           input logic [7:0] data, input int nstart, input string req);
    logic ok;
    ok = (id == dev_id) && (size == 4'h0);
    for (int s = 0; s < nstart; s++) begin step(1'b0, 4'hE); chk_io({req, " R2 start"}, 1'b0, 4'h0, 1'b0); end
    step(1'b1, id); chk_io({req, " R3 id"}, 1'b0, 4'h0, 1'b0);
    for (int i = 6; i >= 0; i--) begin step(1'b1, addr[4*i +: 4]); chk_io({req, " R4 addr"}, 1'b0, 4'h0, 1'b0); end
    step(1'b1, size);      chk_io({req, " R5 size"}, 1'b0, 4'h0, 1'b0);
    step(1'b1, data[3:0]); chk_io({req, " R6 dlo"}, 1'b0, 4'h0, 1'b0);
    step(1'b1, data[7:4]); chk_io({req, " R6 dhi"}, 1'b0, 4'h0, 1'b0);
    step(1'b1, 4'hF);      chk_io({req, " R7 tar"}, ok, 4'hF, 1'b0);
    step(1'b1, 4'hF);      chk_io({req, " R8 sync"}, ok, 4'h0, ok);
    if (ok) begin
      chk_val({req, " R4 wr_addr"}, 32'(wr_addr), 32'(addr));
      chk_val({req, " R6 wr_data"}, 32'(wr_data), 32'(data));
    end
    step(1'b1, 4'hF);      chk_io({req, " R9 tar"}, ok, 4'hF, 1'b0);
    step(1'b1, 4'hF);      chk_io({req, " R9 release"}, 1'b0, 4'h0, 1'b0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_io("R1 in reset", 1'b0, 4'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_io("R1 after reset", 1'b0, 4'h0, 1'b0);

    for (int id = 0; id < 16; id++) run_frame(4'(id), 28'h1234567, 4'h0, 8'hA5, 1, "R3 id sweep");
    for (int sz = 0; sz < 16; sz++) run_frame(4'h5, 28'h0FEDCBA, 4'(sz), 8'h3C, 1, "R5 size sweep");
    for (int d = 0; d < 16; d++) begin
      dev_id = 4'(d);
      run_frame(4'(d), 28'(d * 28'h0111111), 4'h0, 8'(d * 17), 1, "R3 strap sweep");
    end
    dev_id = 4'h5;
    for (int k = 0; k < 28; k++) run_frame(4'h5, 28'h1 << k, 4'h0, 8'(k), 1, "R4 walking addr");
    for (int d = 0; d < 256; d++) run_frame(4'h5, 28'(d * 28'h0123457), 4'h0, 8'(d), 1, "R6 data sweep");
    for (int n = 2; n < 5; n++) run_frame(4'h5, 28'h0A0B0C0, 4'h0, 8'h69, n, "R2 repeated start");

    step(1'b0, 4'hE); step(1'b1, 4'h5); step(1'b1, 4'hA); step(1'b1, 4'hB);
    chk_io("R10 partial", 1'b0, 4'h0, 1'b0);
    run_frame(4'h5, 28'h7654321, 4'h0, 8'hC3, 1, "R10 restart");

    step(1'b0, 4'hE); step(1'b1, 4'h5); step(1'b1, 4'h1); step(1'b1, 4'h2);
    step(1'b0, 4'h3);
    chk_io("R10 abort", 1'b0, 4'h0, 1'b0);
    for (int j = 0; j < 16; j++) begin step(1'b1, 4'h0); chk_io("R10 after abort", 1'b0, 4'h0, 1'b0); end

    step(1'b0, 4'h2);
    for (int j = 0; j < 16; j++) begin step(1'b1, 4'h5); chk_io("R2 non-start low frame", 1'b0, 4'h0, 1'b0); end

    run_frame(4'h5, 28'hFFFFFFF, 4'h0, 8'hFF, 1, "R9 back-to-back a");
    run_frame(4'h5, 28'h0000000, 4'h0, 8'h00, 1, "R9 back-to-back b");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule